// File: doc/BRIEF.md
# Four-Event Capture Sequencer

This block time-stamps transitions on a single input pin. Each accepted transition copies the current time-base count into one of four capture slots. A two-bit slot pointer picks the slot and steps 0, 1, 2, 3. Each slot has its own edge polarity, and its own option to ask the external time base to clear itself after that slot is written. Clearing after a capture turns absolute time stamps into intervals between events.

The pointer runs in one of two modes:
- **Continuous:** the pointer returns to slot 0 after the slot named by the stop/wrap code.
- **One-shot:** the pointer freezes on that slot. No further events are accepted until a re-arm strobe clears the pointer.

An optional prescaler sits in front of the edge logic. It divides the pin's rising-edge rate by an even ratio, and a ratio code of zero bypasses it.

Integration is simple. The pin must already be synchronous to `clk_i`. The caller drives the time-base count into `tbase_i` and clears its counter one cycle after `tb_clr_o` is high.

Top module: `capture_seq`

## Requirements
- R1: The slot the pointer selects accepts only the edge given by its polarity bit (`pol_i[slot]`: 0 = rising, 1 = falling). An edge of the other sense produces no strobe and does not move the pointer.
- R2: On an accepted event, `evt_o` carries a one-cycle one-hot strobe on the bit of the slot, and that slot is written with `tbase_i`. The strobe and the new slot value appear 2 clock edges after the pin changes when the prescaler is bypassed.
- R3: If `rst_en_i[slot]` is 1, `tb_clr_o` pulses together with that slot's strobe. The slot keeps the count from before the clear.
- R4: While `load_en_i` is 0, all four slots keep their values, but accepted events still strobe `evt_o` and advance the pointer.
- R5: In continuous mode (`one_shot_i` = 0), the pointer goes back to slot 0 after the slot whose index equals `stop_sel_i` (codes 0..3 select slots 0..3).
- R6: In one-shot mode (`one_shot_i` = 1), after the event on slot `stop_sel_i` the sequencer freezes. Later edges give no strobe, no slot write and no clear request.
- R7: A one-cycle high on `rearm_i` sets the pointer to slot 0 and unfreezes it. An edge in that same cycle is dropped.
- R8: `presc_i` = 0 bypasses the prescaler. For `presc_i` = N > 0, the event signal toggles on every Nth rising pin edge, which divides the rate by 2N. The rising polarity then fires once per 2N pin pulses.
- R9: After reset, all slots are zero, `evt_o` and `tb_clr_o` are low, and the pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Synchronized event pin |
| tbase_i | input | 32 | Time-base count to capture |
| pol_i | input | 4 | Per-slot edge polarity, 1 = falling |
| rst_en_i | input | 4 | Per-slot time-base clear request enable |
| load_en_i | input | 1 | Capture write enable |
| one_shot_i | input | 1 | 1 = one-shot, 0 = continuous |
| stop_sel_i | input | 2 | Stop / wrap slot index |
| rearm_i | input | 1 | Re-arm strobe |
| presc_i | input | 5 | Prescale code, ratio 2N, 0 = bypass |
| cap_o | output | 4x32 | Capture slots, slot i at [i] |
| evt_o | output | 4 | One-hot per-slot event strobe |
| tb_clr_o | output | 1 | Time-base clear request |

## Verification
A wrong pointer is visible at once: the next strobe lands on the wrong bit of `evt_o`, and the timestamp goes into the wrong slot. The scoreboard expects a specific slot for every event, so the error shows up at the first event after it.

A lost freeze flag shows up as a strobe the scoreboard never queued. A missed write or stale write enable leaves a slot different from the count the bench saw at the capture edge.

A prescaler count off by one shifts the events to other pin pulses. That leaves items in the queue at the end, or produces strobes that were not expected.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CS_NUM_EV = 4;
  typedef enum logic {
    MODE_CONT    = 1'b0,
    MODE_ONESHOT = 1'b1
  } run_mode_e;
endpackage

// File: rtl/cs_prescaler.sv
module cs_prescaler #(
  parameter int PS_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pin_i,
  input  logic [PS_W-1:0] ratio_i,
  output logic            sig_o
);
  logic            pin_q, pin_qq, div_q;
  logic [PS_W-1:0] cnt_q;
  logic            pin_rise;
  logic            bypass;

  assign pin_rise = pin_q & ~pin_qq;
  assign bypass   = (ratio_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      pin_qq <= 1'b0;
      div_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pin_q  <= pin_i;
      pin_qq <= pin_q;
      if (bypass) begin
        cnt_q <= '0;
      end else if (pin_rise) begin
        if (cnt_q >= ratio_i - 1'b1) begin
          cnt_q <= '0;
          div_q <= ~div_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sig_o = bypass ? pin_q : div_q;
endmodule

// File: rtl/cs_edge_sel.sv
module cs_edge_sel #(
  parameter int NUM_EV = 4,
  parameter int PTR_W  = $clog2(NUM_EV)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sig_i,
  input  logic [NUM_EV-1:0] pol_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic              hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise  = sig_i & ~prev_q;
  assign fall  = ~sig_i & prev_q;
  assign hit_o = pol_i[ptr_i] ? fall : rise;
endmodule

// File: rtl/cs_slot_ctrl.sv
module cs_slot_ctrl #(
  parameter int NUM_EV = 4,
  parameter int PTR_W  = $clog2(NUM_EV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  cs_pkg::run_mode_e mode_i,
  input  logic [PTR_W-1:0] stop_i,
  input  logic             rearm_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             frozen_o,
  output logic             take_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             frozen_q;

  // rearm wins over a coincident edge
  assign take_o = hit_i & ~frozen_q & ~rearm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      frozen_q <= 1'b0;
    end else if (rearm_i) begin
      ptr_q    <= '0;
      frozen_q <= 1'b0;
    end else if (take_o) begin
      if (ptr_q == stop_i) begin
        if (mode_i == cs_pkg::MODE_ONESHOT) frozen_q <= 1'b1;
        else                                ptr_q    <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign ptr_o    = ptr_q;
  assign frozen_o = frozen_q;
endmodule

// File: rtl/capture_seq.sv
module capture_seq #(
  parameter int NUM_EV = cs_pkg::CS_NUM_EV,
  parameter int TS_W   = 32,
  parameter int PS_W   = 5,
  localparam int PTR_W = $clog2(NUM_EV)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         pin_i,
  input  logic [TS_W-1:0]              tbase_i,
  input  logic [NUM_EV-1:0]            pol_i,
  input  logic [NUM_EV-1:0]            rst_en_i,
  input  logic                         load_en_i,
  input  logic                         one_shot_i,
  input  logic [PTR_W-1:0]             stop_sel_i,
  input  logic                         rearm_i,
  input  logic [PS_W-1:0]              presc_i,
  output logic [NUM_EV-1:0][TS_W-1:0]  cap_o,
  output logic [NUM_EV-1:0]            evt_o,
  output logic                         tb_clr_o
);
  logic             ev_sig;
  logic             hit;
  logic             take;
  logic [PTR_W-1:0] slot_ptr;
  logic             slot_frozen;
  logic             clr_q;
  cs_pkg::run_mode_e mode;

  assign mode = one_shot_i ? cs_pkg::MODE_ONESHOT : cs_pkg::MODE_CONT;

  cs_prescaler #(.PS_W(PS_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .ratio_i(presc_i),
    .sig_o  (ev_sig)
  );

  cs_edge_sel #(.NUM_EV(NUM_EV), .PTR_W(PTR_W)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (ev_sig),
    .pol_i (pol_i),
    .ptr_i (slot_ptr),
    .hit_o (hit)
  );

  cs_slot_ctrl #(.NUM_EV(NUM_EV), .PTR_W(PTR_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .mode_i  (mode),
    .stop_i  (stop_sel_i),
    .rearm_i (rearm_i),
    .ptr_o   (slot_ptr),
    .frozen_o(slot_frozen),
    .take_o  (take)
  );

  for (genvar i = 0; i < NUM_EV; i++) begin : g_slot
    logic            sel;
    logic [TS_W-1:0] cap_q;
    logic            evt_q;
    assign sel = take && (slot_ptr == PTR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_q <= '0;
        evt_q <= 1'b0;
      end else begin
        evt_q <= sel;
        if (sel && load_en_i) cap_q <= tbase_i;
      end
    end
    assign cap_o[i] = cap_q;
    assign evt_o[i] = evt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= take & rst_en_i[slot_ptr];
  end

  assign tb_clr_o = clr_q;
endmodule

// File: rtl/capture_seq_chk.sv
module capture_seq_chk #(
  parameter int NUM_EV = 4,
  parameter int TS_W   = 32,
  parameter int PTR_W  = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        rearm_i,
  input logic                        load_en_i,
  input logic [NUM_EV-1:0]           rst_en_i,
  input logic [NUM_EV-1:0][TS_W-1:0] cap_o,
  input logic [NUM_EV-1:0]           evt_o,
  input logic                        tb_clr_o,
  input logic [PTR_W-1:0]            slot_ptr,
  input logic                        slot_frozen
);
  AST_EVT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_o)); // R2
  AST_EVT_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o != '0) |-> (evt_o == (NUM_EV'(1) << $past(slot_ptr)))); // R5
  AST_CLR_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_clr_o |-> ((evt_o & $past(rst_en_i)) != '0)); // R3
  AST_LOAD_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_en_i) |-> $stable(cap_o)); // R4
  AST_FROZEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_frozen && !rearm_i) |=> (evt_o == '0 && !tb_clr_o)); // R6
  AST_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (slot_ptr == '0 && !slot_frozen)); // R7
endmodule

bind capture_seq capture_seq_chk #(.NUM_EV(NUM_EV), .TS_W(TS_W), .PTR_W(PTR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rearm_i    (rearm_i),
  .load_en_i  (load_en_i),
  .rst_en_i   (rst_en_i),
  .cap_o      (cap_o),
  .evt_o      (evt_o),
  .tb_clr_o   (tb_clr_o),
  .slot_ptr   (slot_ptr),
  .slot_frozen(slot_frozen)
);

// File: tb/capture_seq_tb.sv
module capture_seq_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pin = 1'b0;
  logic [31:0]       tb_q = '0;
  logic [31:0]       tb_last = '0;
  logic [3:0]        pol = '0;
  logic [3:0]        rst_en = '0;
  logic              load_en = 1'b1;
  logic              one_shot = 1'b0;
  logic [1:0]        stop_sel = 2'd3;
  logic              rearm = 1'b0;
  logic [4:0]        presc = '0;
  logic [3:0][31:0]  cap;
  logic [3:0][31:0]  cap_prev = '0;
  logic [3:0]        evt;
  logic              tb_clr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int slot;
    bit clr;
    bit load;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  capture_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .tbase_i(tb_q),
    .pol_i(pol), .rst_en_i(rst_en), .load_en_i(load_en),
    .one_shot_i(one_shot), .stop_sel_i(stop_sel), .rearm_i(rearm),
    .presc_i(presc), .cap_o(cap), .evt_o(evt), .tb_clr_o(tb_clr)
  );

  // time-base model: tb_last is the count the design sampled at the last edge
  always @(posedge clk) begin
    tb_last <= tb_q;
    tb_q    <= tb_clr ? 32'd0 : tb_q + 32'd1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per strobe
  always @(negedge clk) begin
    if (rst_n && !done && evt != '0) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected strobe", 64'(evt), 64'd0);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        chk(evt == 4'(1 << it.slot), {it.req, " slot"}, 64'(evt), 64'(1 << it.slot));
        chk(tb_clr == it.clr, "R3 clear request", 64'(tb_clr), 64'(it.clr));
        if (it.load)
          chk(cap[it.slot] == tb_last, {it.req, " R2 captured count"}, 64'(cap[it.slot]), 64'(tb_last));
        else
          chk(cap[it.slot] == cap_prev[it.slot], "R4 slot held", 64'(cap[it.slot]), 64'(cap_prev[it.slot]));
      end
    end
    cap_prev = cap;
  end

  task automatic push(input int slot, input bit clr, input bit load, input string req);
    exp_t it;
    it.slot = slot; it.clr = clr; it.load = load; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input bit lvl, input bit exp, input int slot, input bit clr, input bit load, input string req);
    if (exp) push(slot, clr, load, req);
    @(negedge clk);
    pin = lvl;
    settle(5);
  endtask

  task automatic pulse(input bit exp, input int slot, input bit clr, input bit load, input string req);
    set_pin(1'b1, exp, slot, clr, load, req);
    set_pin(1'b0, 1'b0, 0, 1'b0, 1'b0, req);
  endtask

  task automatic do_rearm();
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    // R9 reset state
    chk(cap == '0, "R9 slots zero", 64'(cap[0] | cap[1] | cap[2] | cap[3]), 64'd0);
    chk(evt == '0, "R9 no strobe", 64'(evt), 64'd0);
    chk(tb_clr == 1'b0, "R9 no clear", 64'(tb_clr), 64'd0);

    // R2 / R5: continuous, wrap after slot 3
    for (int k = 0; k < 5; k++) pulse(1'b1, k % 4, 1'b0, 1'b1, "R5 cont wrap3");

    // R1: per-slot polarity
    do_rearm();
    pol = 4'b1010;
    set_pin(1'b1, 1'b1, 0, 1'b0, 1'b1, "R1 slot0 rise");
    set_pin(1'b0, 1'b1, 1, 1'b0, 1'b1, "R1 slot1 fall");
    set_pin(1'b1, 1'b1, 2, 1'b0, 1'b1, "R1 slot2 rise");
    set_pin(1'b0, 1'b1, 3, 1'b0, 1'b1, "R1 slot3 fall");
    pol = 4'b0001;
    set_pin(1'b1, 1'b0, 0, 1'b0, 1'b1, "R1 wrong edge ignored");
    set_pin(1'b0, 1'b1, 0, 1'b0, 1'b1, "R1 slot0 fall");
    pol = 4'b0000;

    // R5: wrap after slot 1
    do_rearm();
    stop_sel = 2'd1;
    pulse(1'b1, 0, 1'b0, 1'b1, "R5 wrap1");
    pulse(1'b1, 1, 1'b0, 1'b1, "R5 wrap1");
    pulse(1'b1, 0, 1'b0, 1'b1, "R5 wrap1 back to 0");

    // R6: one-shot stop after slot 2
    do_rearm();
    one_shot = 1'b1;
    stop_sel = 2'd2;
    for (int k = 0; k < 5; k++) pulse(k < 3, k, 1'b0, 1'b1, "R6 one-shot");
    // R7: rearm restarts at slot 0
    do_rearm();
    pulse(1'b1, 0, 1'b0, 1'b1, "R7 rearm");
    one_shot = 1'b0;
    stop_sel = 2'd3;

    // R4: loads disabled
    do_rearm();
    load_en = 1'b0;
    pulse(1'b1, 0, 1'b0, 1'b0, "R4 no load");
    pulse(1'b1, 1, 1'b0, 1'b0, "R4 no load");
    load_en = 1'b1;

    // R3: clear after slot 1, pre-clear count kept
    do_rearm();
    rst_en = 4'b0010;
    pulse(1'b1, 0, 1'b0, 1'b1, "R3 diff");
    pulse(1'b1, 1, 1'b1, 1'b1, "R3 diff clr");
    pulse(1'b1, 2, 1'b0, 1'b1, "R3 diff");
    chk(cap[1] > cap[2], "R3 pre-clear count kept", 64'(cap[1]), 64'(cap[2]));
    chk(cap[2] < 32'd20, "R3 interval after clear", 64'(cap[2]), 64'd20);
    rst_en = 4'b0000;

    // R8: prescale code 2 -> divide by 4
    do_rearm();
    presc = 5'd2;
    for (int k = 1; k <= 8; k++) pulse(k == 2 || k == 6, (k == 2) ? 0 : 1, 1'b0, 1'b1, "R8 prescale");
    settle(4);
    chk(exp_q.size() == 0, "R8 all expected events seen", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule